// File: doc/BRIEF.md
# Serial Audio Word Splitter for Paired DACs

This block sits between a serial audio source and two lower-resolution DACs that together reproduce a 24-bit two's-complement signal. It runs on the incoming bit clock and watches the left/right word select line. Each channel word arrives MSB first, starting in the bit period right after a word-select change, in a slot of 32 bit clocks. The block captures the 24 data bits and ignores the rest of the slot. In the following slot it sends the word out again as two 16-bit right-justified frames, one on each DAC data line. Both DACs keep the original bit clock and word select. Only their data lines come from this block.

The high line carries sample bits 23..8. The low line carries bits 7..0, preceded by eight copies of sample bit 23. This makes the low DAC read its 16-bit word as a two's-complement value whose sign is the sign of the whole sample. Without the copies, the low DAC would treat bit 7 as its sign bit and invert its output whenever bit 7 and bit 23 differ. Both frames finish on the word-select change that latches them, so the two DACs update together one slot after capture.

Capture is a state machine with three states. ST_WAIT is the state after reset: no slot boundary seen yet. ST_SHIFT is taking in data bits. ST_PAD means all 24 bits are held and the rest of the slot is ignored. Transitions:
- ST_WAIT→ST_SHIFT on a word-select change.
- ST_SHIFT→ST_PAD when the 24th bit is taken.
- ST_SHIFT→ST_SHIFT on a word-select change that arrives early, which restarts capture.
- ST_PAD→ST_SHIFT on the next word-select change.

Top module: `audio_word_splitter`

## Requirements
- R1: After synchronous reset both data outputs are 0 and stay 0 until a complete 24-bit word has been captured and its output slot begins.
- R2: A word is captured MSB first. Bit 23 is the `ser_in` value sampled on the bit-clock rising edge where `word_sel` differs from its previous sampled value, and bits 22..0 are sampled on the next 23 edges. `ser_in` in slot positions 24..31 has no effect on any output.
- R3: In the slot after capture, `hi_line` at slot positions 16..31 carries sample bits 23..8, MSB first. Position p is the value after the p-th rising edge of the slot, counting the word-select change edge as position 0.
- R4: In the slot after capture, `lo_line` carries sample bit 23 at positions 16..23 and sample bits 7..0 at positions 24..31, MSB first.
- R5: Both data outputs are 0 at slot positions 0..15.
- R6: Both lines carry the same captured word in the same slot, a latency of one slot (32 bit clocks).
- R7: When sample bit 7 differs from bit 23, the eight bits in front of bits 7..0 on `lo_line` still equal bit 23.
- R8: If `word_sel` changes before 24 bits of a word are taken, that word is dropped, and both outputs stay 0 for the whole following slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial bit clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| word_sel | input | 1 | Left/right word select; each change starts a channel slot |
| ser_in | input | 1 | Serial 24-bit two's-complement input data, left-justified |
| hi_line | output | 1 | Serial data to the DAC for the 16 upper bits |
| lo_line | output | 1 | Serial data to the DAC for the sign-extended 8 lower bits |

## Verification
Directed words pair bit 23 with the opposite value of bit 7 (7FFF80, 80007F). These show whether the low frame is extended from the true sign or from its own top bit. Full-scale positive and negative words and the one-LSB word show bit-order and lane-swap errors. Random words, with random filler in the unused slot positions, check that the filler never reaches either line. A deliberately short slot separates dropping an incomplete word from passing on stale or partial data.

// File: rtl/splitter_pkg.sv
package splitter_pkg;
    typedef enum logic [1:0] {
        ST_WAIT,
        ST_SHIFT,
        ST_PAD
    } cap_state_t;

    localparam int SAMPLE_BITS = 24;
    localparam int HIGH_BITS   = 16;
    localparam int SLOT_BITS   = 32;
endpackage

// File: rtl/splitter_capture.sv
module splitter_capture
    import splitter_pkg::*;
#(
    parameter int SAMPLE_W = SAMPLE_BITS
) (
    input  logic                bit_clk,
    input  logic                rst,
    input  logic                word_sel,
    input  logic                ser_in,
    output logic                slot_edge,
    output logic                word_ok,
    output logic [SAMPLE_W-1:0] word
);
    localparam int BCNT_W = $clog2(SAMPLE_W + 1);

    cap_state_t          state, state_nx;
    logic                sel_q;
    logic [SAMPLE_W-1:0] sreg;
    logic [BCNT_W-1:0]   bcnt;

    assign slot_edge = word_sel ^ sel_q;

    // state register and shifter
    always_ff @(posedge bit_clk) begin
        if (rst) begin
            state <= ST_WAIT;
            sel_q <= 1'b0;
            sreg  <= '0;
            bcnt  <= '0;
        end else begin
            state <= state_nx;
            sel_q <= word_sel;
            if (slot_edge) begin
                sreg <= {{(SAMPLE_W-1){1'b0}}, ser_in};
                bcnt <= BCNT_W'(1);
            end else if (state == ST_SHIFT) begin
                sreg <= {sreg[SAMPLE_W-2:0], ser_in};
                bcnt <= bcnt + 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAIT:  if (slot_edge) state_nx = ST_SHIFT;
            ST_SHIFT: begin
                if (slot_edge)
                    state_nx = ST_SHIFT;
                else if (bcnt == BCNT_W'(SAMPLE_W - 1))
                    state_nx = ST_PAD;
            end
            ST_PAD:   if (slot_edge) state_nx = ST_SHIFT;
            default:  state_nx = ST_WAIT;
        endcase
    end

    // outputs
    always_comb begin
        word_ok = (state == ST_PAD);
        word    = sreg;
    end

    assert_pad_full_R2: assert property (@(posedge bit_clk) disable iff (rst)
        (state == ST_PAD) |-> (bcnt == BCNT_W'(SAMPLE_W)));
endmodule

// File: rtl/splitter_lane.sv
module splitter_lane #(
    parameter int FRAME_W = 16,
    parameter int SLOT_W  = 32,
    localparam int POS_W  = $clog2(SLOT_W)
) (
    input  logic               bit_clk,
    input  logic               rst,
    input  logic               slot_edge,
    input  logic               load_ok,
    input  logic [FRAME_W-1:0] frame,
    output logic               dout,
    output logic [POS_W-1:0]   pos
);
    localparam int START = SLOT_W - FRAME_W;

    logic [FRAME_W-1:0] sh;
    logic               at_end;
    logic               in_frame;

    always_comb begin
        at_end   = (pos == POS_W'(SLOT_W - 1));
        in_frame = !at_end && ((pos + 1'b1) >= POS_W'(START));
    end

    always_ff @(posedge bit_clk) begin
        if (rst) begin
            sh   <= '0;
            pos  <= '0;
            dout <= 1'b0;
        end else if (slot_edge) begin
            sh   <= load_ok ? frame : '0;
            pos  <= '0;
            dout <= 1'b0;
        end else begin
            if (!at_end) pos <= pos + 1'b1;
            if (in_frame) begin
                dout <= sh[FRAME_W-1];
                sh   <= {sh[FRAME_W-2:0], 1'b0};
            end else begin
                dout <= 1'b0;
            end
        end
    end

    assert_head_low_R5: assert property (@(posedge bit_clk) disable iff (rst)
        (pos < POS_W'(START)) |-> !dout);
endmodule

// File: rtl/audio_word_splitter.sv
module audio_word_splitter
    import splitter_pkg::*;
#(
    parameter int SAMPLE_W = SAMPLE_BITS,
    parameter int HIGH_W   = HIGH_BITS,
    parameter int SLOT_W   = SLOT_BITS
) (
    input  logic bit_clk,
    input  logic rst,
    input  logic word_sel,
    input  logic ser_in,
    output logic hi_line,
    output logic lo_line
);
    localparam int LOW_W   = SAMPLE_W - HIGH_W;
    localparam int FRAME_W = HIGH_W;
    localparam int EXT_W   = FRAME_W - LOW_W;
    localparam int START   = SLOT_W - FRAME_W;
    localparam int POS_W   = $clog2(SLOT_W);
    localparam int NLANE   = 2;

    logic                slot_edge;
    logic                word_ok;
    logic [SAMPLE_W-1:0] word;
    logic                have_word;
    logic [FRAME_W-1:0]  frames    [NLANE];
    logic                lane_dout [NLANE];
    logic [POS_W-1:0]    lane_pos  [NLANE];

    splitter_capture #(.SAMPLE_W(SAMPLE_W)) u_capture (
        .bit_clk  (bit_clk),
        .rst      (rst),
        .word_sel (word_sel),
        .ser_in   (ser_in),
        .slot_edge(slot_edge),
        .word_ok  (word_ok),
        .word     (word)
    );

    // lane 0: upper bits; lane 1: sign copies then lower bits
    assign frames[0] = word[SAMPLE_W-1 -: HIGH_W];
    assign frames[1] = {{EXT_W{word[SAMPLE_W-1]}}, word[LOW_W-1:0]};

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        splitter_lane #(.FRAME_W(FRAME_W), .SLOT_W(SLOT_W)) u_lane (
            .bit_clk  (bit_clk),
            .rst      (rst),
            .slot_edge(slot_edge),
            .load_ok  (word_ok),
            .frame    (frames[g]),
            .dout     (lane_dout[g]),
            .pos      (lane_pos[g])
        );
    end

    always_ff @(posedge bit_clk) begin
        if (rst)                        have_word <= 1'b0;
        else if (slot_edge && word_ok)  have_word <= 1'b1;
    end

    assign hi_line = lane_dout[0];
    assign lo_line = lane_dout[1];

    assert_silent_until_word_R1: assert property (@(posedge bit_clk) disable iff (rst)
        !have_word |-> (!hi_line && !lo_line));

    assert_sign_match_R4: assert property (@(posedge bit_clk) disable iff (rst)
        (lane_pos[1] == POS_W'(START)) |-> (lo_line == hi_line));

    assert_sign_hold_R7: assert property (@(posedge bit_clk) disable iff (rst)
        ((lane_pos[1] > POS_W'(START)) && (lane_pos[1] < POS_W'(START + EXT_W)))
        |-> $stable(lo_line));

    assert_lanes_aligned_R6: assert property (@(posedge bit_clk) disable iff (rst)
        lane_pos[0] == lane_pos[1]);
endmodule

// File: tb/audio_word_splitter_bench.sv
module audio_word_splitter_bench;
    logic bit_clk = 1'b0;
    logic rst = 1'b1;
    logic word_sel = 1'b0;
    logic ser_in = 1'b0;
    logic hi_line, lo_line;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // pending expectation for the value after the most recent edge
    bit        pend = 1'b0;
    bit        pend_ok;
    logic [23:0] pend_w;
    int        pend_p;
    bit        pend_r1;
    bit        pend_r8;

    logic [23:0] prev_w = '0;
    bit        prev_ok = 1'b0;
    bit        first_slot = 1'b1;
    bit        prev_short = 1'b0;

    always #5 bit_clk = ~bit_clk;

    audio_word_splitter u_audio_word_splitter (
        .bit_clk (bit_clk),
        .rst     (rst),
        .word_sel(word_sel),
        .ser_in  (ser_in),
        .hi_line (hi_line),
        .lo_line (lo_line)
    );

    function automatic logic exp_hi(bit ok, logic [23:0] w, int p);
        if (!ok || p < 16) return 1'b0;
        return w[39 - p];
    endfunction

    function automatic logic exp_lo(bit ok, logic [23:0] w, int p);
        if (!ok || p < 16) return 1'b0;
        if (p < 24) return w[23];
        return w[31 - p];
    endfunction

    task automatic check_bit(string req, logic act, logic exp, int p);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s pos %0d: actual %b expected %b", req, p, act, exp);
        end
    endtask

    task automatic check_pending();
        string rh, rl;
        if (!pend) return;
        if (pend_r1)        begin rh = "R1"; rl = "R1"; end
        else if (pend_r8)   begin rh = "R8"; rl = "R8"; end
        else if (pend_p < 16) begin rh = "R5"; rl = "R5"; end
        else begin
            rh = "R3";
            rl = (pend_w[23] != pend_w[7]) ? "R7" : "R4";
        end
        // R6: both lines judged against the same word and position
        check_bit({rh, " hi"}, hi_line, exp_hi(pend_ok, pend_w, pend_p), pend_p);
        check_bit({rl, " lo"}, lo_line, exp_lo(pend_ok, pend_w, pend_p), pend_p);
    endtask

    // one channel slot of len bit clocks carrying w
    task automatic run_slot(logic [23:0] w, int len);
        for (int p = 0; p < len; p++) begin
            @(negedge bit_clk);
            check_pending();
            if (p == 0) word_sel = ~word_sel;
            // R2: filler after bit 0 is random and must not leak
            ser_in = (p < 24) ? w[23 - p] : 1'($urandom);
            pend    = 1'b1;
            pend_ok = prev_ok;
            pend_w  = prev_w;
            pend_p  = p;
            pend_r1 = first_slot;
            pend_r8 = prev_short;
        end
        first_slot = 1'b0;
        prev_short = (len < 24);
        prev_ok    = (len >= 24);
        prev_w     = w;
    endtask

    initial begin
        repeat (20000) @(posedge bit_clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge bit_clk);
        rst = 1'b0;
        @(negedge bit_clk);
        // R1: reset state
        check_bit("R1 hi", hi_line, 1'b0, 0);
        check_bit("R1 lo", lo_line, 1'b0, 0);
        run_slot(24'h7FFF80, 32);   // first slot: output silent (R1)
        run_slot(24'h80007F, 32);   // R7: bit7 differs from bit23
        run_slot(24'h800000, 32);
        run_slot(24'h7FFFFF, 32);
        run_slot(24'hFFFFFF, 32);
        run_slot(24'h000001, 32);
        run_slot(24'hA5C3F0, 12);   // short slot, word dropped (R8)
        run_slot(24'h123456, 32);   // output silent here
        run_slot(24'hFEDC80, 32);
        for (int i = 0; i < 200; i++)
            run_slot(24'($urandom), 32);
        run_slot(24'h000000, 32);   // flush last random word
        @(negedge bit_clk);
        check_pending();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule